// File: doc/BRIEF.md
# System Clock Source Switch

This block chooses which of two free-running oscillators, a fast RC oscillator or a 32.768 kHz crystal oscillator, drives the system clock of a small controller. Software programs an 8-bit control register on the bus clock. The register holds the wanted source, a stop control for each oscillator, the warm-up length and a wait-mode selection that is passed on to the power-down logic.

When software asks for the other source, the block counts rising edges of the target oscillator. It counts either a short or a long warm-up. It then hands the clock over through a break-before-make gate, with each enable resynchronised in its own oscillator domain. The source bit reads back the oscillator that is actually driving the clock, so software polls that bit to learn when the handover has finished. The gated clock is halved before it leaves the block.

Top module: `clk_src_switch`

## Requirements
- R1: After reset the register reads 0x00, both stop outputs and `waitSel` are 0, and the RC oscillator drives `sysClk`.
- R2: Bit 7 of `rdData` (0 = RC, 1 = crystal) shows the source that is driving `sysClk`. After a write that requests the other source, it keeps the old value until the handover is complete.
- R3: Bit 6 drives `rcStop` and bit 5 drives `xtalStop` (1 = stopped). Both read back as written, except where R8 applies.
- R4: Bit 4 is a test bit and bits 1:0 are not implemented. They always read 0, and writing them changes nothing.
- R5: Bit 2 is stored and drives `waitSel`. It reads back as written.
- R6: Bit 3 sets the warm-up length. With 1, the handover completes no earlier than 16 rising edges of the target oscillator after the request. With 0, it completes no earlier than 256 edges. The length is the value of bit 3 when the request is taken.
- R7: A request to switch to an oscillator whose stop bit is 1 does not complete while that bit stays 1. Once the bit is cleared, the warm-up runs and the switch completes.
- R8: A write that sets the stop bit of the oscillator driving `sysClk`, or of the oscillator the gate is handing over to, leaves that stop bit at 0.
- R9: `sysClk` runs at half the frequency of the selected oscillator. No half period of `sysClk` is ever shorter than one period of the faster oscillator, including during a handover.
- R10: If software writes the current source back into bit 7 before the warm-up ends, the request is dropped and bit 7 does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Register and sequencing clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register readback |
| rcClk | input | 1 | RC oscillator clock |
| xtalClk | input | 1 | Crystal oscillator clock |
| rcStop | output | 1 | Stop request to the RC oscillator |
| xtalStop | output | 1 | Stop request to the crystal oscillator |
| waitSel | output | 1 | Wait-mode selection for the power-down logic |
| sysClk | output | 1 | Selected oscillator divided by two |

## Verification
The bench times each handover in bus cycles and checks the time against the 16-edge and 256-edge bounds. A design that counted the wrong oscillator, or that ignored the length bit, would finish too early or too late. A monitor measures every `sysClk` half period, so a gate that let the two clocks overlap or produced a runt pulse would be reported. Other tests check protection of the running oscillator's stop bit, a request aimed at a stopped oscillator that must stall until the oscillator is enabled, and a request withdrawn during warm-up that must not flip the source bit.

// File: rtl/clk_sw_pkg.sv
`timescale 1ns/1ps
package clk_sw_pkg;
  typedef struct packed {
    logic cntClr;    // hold warm-up count at zero
    logic cntEn;     // count target edges
    logic cntShort;  // short warm-up limit
    logic target;    // oscillator being warmed up
    logic muxSel;    // source requested from the clock gate
  } swStrobes_t;

  typedef enum logic [1:0] {SW_IDLE, SW_WARM, SW_SWAP} swState_t;
endpackage

// File: rtl/clk_sw_sync.sv
`timescale 1ns/1ps
module clk_sw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/clk_sw_datapath.sv
`timescale 1ns/1ps
module clk_sw_datapath
  import clk_sw_pkg::*;
#(
  parameter int LONG_WARM   = 256,
  parameter int SHORT_WARM  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       busClk,
  input  logic       rstN,
  input  logic       rcClk,
  input  logic       xtalClk,
  input  swStrobes_t strobes,
  output logic       warmDone,
  output logic       rcRunning,
  output logic       xtalRunning,
  output logic       sysClk
);
  localparam int CNT_W = $clog2(LONG_WARM + 1);

  // oscillator levels seen in the bus domain, for edge counting
  logic rcLvl, xtalLvl, rcLvlD, xtalLvlD, targetRise;
  clk_sw_sync #(.STAGES(SYNC_STAGES + 1)) i_rcLvl (
    .clk(busClk), .rstN(rstN), .d(rcClk), .q(rcLvl));
  clk_sw_sync #(.STAGES(SYNC_STAGES + 1)) i_xtalLvl (
    .clk(busClk), .rstN(rstN), .d(xtalClk), .q(xtalLvl));

  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      rcLvlD   <= 1'b0;
      xtalLvlD <= 1'b0;
    end else begin
      rcLvlD   <= rcLvl;
      xtalLvlD <= xtalLvl;
    end
  end

  assign targetRise = strobes.target ? (xtalLvl & ~xtalLvlD) : (rcLvl & ~rcLvlD);

  // warm-up counter
  logic [CNT_W-1:0] warmCnt;
  logic [CNT_W-1:0] warmLimit;
  assign warmLimit = strobes.cntShort ? CNT_W'(SHORT_WARM) : CNT_W'(LONG_WARM);
  assign warmDone  = (warmCnt >= warmLimit);

  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN)                                      warmCnt <= '0;
    else if (strobes.cntClr)                        warmCnt <= '0;
    else if (strobes.cntEn && targetRise && !warmDone) warmCnt <= warmCnt + 1'b1;
  end

  AST_COUNT_BOUNDED: assert property (@(posedge busClk) disable iff (!rstN)
    warmCnt <= CNT_W'(LONG_WARM)); // R6

  // break-before-make clock gate: each enable changes on its own falling edge
  logic rcReq, xtalReq, rcEn, xtalEn;
  assign rcReq   = ~strobes.muxSel & ~xtalEn;
  assign xtalReq =  strobes.muxSel & ~rcEn;

  clk_sw_sync #(.STAGES(SYNC_STAGES)) i_rcEn (
    .clk(~rcClk), .rstN(rstN), .d(rcReq), .q(rcEn));
  clk_sw_sync #(.STAGES(SYNC_STAGES)) i_xtalEn (
    .clk(~xtalClk), .rstN(rstN), .d(xtalReq), .q(xtalEn));

  always_comb begin
    if (rstN) AST_EXCLUSIVE_ENABLE: assert (!(rcEn && xtalEn)); // R9
  end

  // running status back to the bus domain
  clk_sw_sync #(.STAGES(SYNC_STAGES)) i_rcRun (
    .clk(busClk), .rstN(rstN), .d(rcEn), .q(rcRunning));
  clk_sw_sync #(.STAGES(SYNC_STAGES)) i_xtalRun (
    .clk(busClk), .rstN(rstN), .d(xtalEn), .q(xtalRunning));

  // gated clock and divide-by-two
  logic gatedClk, divQ;
  assign gatedClk = (rcClk & rcEn) | (xtalClk & xtalEn);

  always_ff @(posedge gatedClk or negedge rstN) begin
    if (!rstN) divQ <= 1'b0;
    else       divQ <= ~divQ;
  end

  assign sysClk = divQ;
endmodule

// File: rtl/clk_sw_ctrl.sv
`timescale 1ns/1ps
module clk_sw_ctrl
  import clk_sw_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              busClk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rcStop,
  output logic              xtalStop,
  output logic              waitSel,
  input  logic              warmDone,
  input  logic              rcRunning,
  input  logic              xtalRunning,
  output swStrobes_t        strobes
);
  localparam int SEL_BIT    = DATA_W - 1;
  localparam int RCSTOP_BIT = DATA_W - 2;
  localparam int XSTOP_BIT  = DATA_W - 3;
  localparam int SHORT_BIT  = DATA_W - 5;
  localparam int WAIT_BIT   = DATA_W - 6;

  logic     selReq, rcStopQ, xtalStopQ, shortQ, waitQ;
  logic     actualQ, muxSelQ, shortLatchQ;
  swState_t state;

  // register writes; stopping a clock in use is refused
  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      selReq    <= 1'b0;
      rcStopQ   <= 1'b0;
      xtalStopQ <= 1'b0;
      shortQ    <= 1'b0;
      waitQ     <= 1'b0;
    end else if (wrEn) begin
      selReq    <= wrData[SEL_BIT];
      rcStopQ   <= wrData[RCSTOP_BIT] & actualQ & muxSelQ;
      xtalStopQ <= wrData[XSTOP_BIT] & ~actualQ & ~muxSelQ;
      shortQ    <= wrData[SHORT_BIT];
      waitQ     <= wrData[WAIT_BIT];
    end
  end

  always_comb begin
    rdData             = '0;
    rdData[SEL_BIT]    = actualQ;
    rdData[RCSTOP_BIT] = rcStopQ;
    rdData[XSTOP_BIT]  = xtalStopQ;
    rdData[SHORT_BIT]  = shortQ;
    rdData[WAIT_BIT]   = waitQ;
  end

  assign rcStop   = rcStopQ;
  assign xtalStop = xtalStopQ;
  assign waitSel  = waitQ;

  // switch sequencing
  logic targetStopped, targetUp;
  assign targetStopped = selReq ? xtalStopQ : rcStopQ;
  assign targetUp      = muxSelQ ? (xtalRunning & ~rcRunning) : (rcRunning & ~xtalRunning);

  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      state       <= SW_IDLE;
      actualQ     <= 1'b0;
      muxSelQ     <= 1'b0;
      shortLatchQ <= 1'b0;
    end else begin
      unique case (state)
        SW_IDLE: if (selReq != actualQ) begin
          shortLatchQ <= shortQ;
          state       <= SW_WARM;
        end
        SW_WARM: if (selReq == actualQ) begin
          state <= SW_IDLE;
        end else if (warmDone) begin
          muxSelQ <= selReq;
          state   <= SW_SWAP;
        end
        SW_SWAP: if (targetUp) begin
          actualQ <= muxSelQ;
          state   <= SW_IDLE;
        end
        default: state <= SW_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.cntClr   = (state == SW_IDLE);
    strobes.cntEn    = (state == SW_WARM) && !targetStopped;
    strobes.cntShort = shortLatchQ;
    strobes.target   = selReq;
    strobes.muxSel   = muxSelQ;
  end

  AST_STOP_SPARES_ACTIVE: assert property (@(posedge busClk) disable iff (!rstN)
    !(actualQ ? xtalStop : rcStop)); // R8
  AST_SWITCH_AFTER_SWAP: assert property (@(posedge busClk) disable iff (!rstN)
    (actualQ != $past(actualQ)) |-> ($past(state) == SW_SWAP)); // R2
  AST_MUX_AFTER_WARM: assert property (@(posedge busClk) disable iff (!rstN)
    (muxSelQ != $past(muxSelQ)) |-> $past(warmDone)); // R6
  AST_WAIT_TRACKS_WRITE: assert property (@(posedge busClk) disable iff (!rstN)
    wrEn |=> (waitSel == $past(wrData[WAIT_BIT]))); // R5
endmodule

// File: rtl/clk_src_switch.sv
`timescale 1ns/1ps
module clk_src_switch
  import clk_sw_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int LONG_WARM   = 256,
  parameter int SHORT_WARM  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              busClk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              rcClk,
  input  logic              xtalClk,
  output logic              rcStop,
  output logic              xtalStop,
  output logic              waitSel,
  output logic              sysClk
);
  swStrobes_t strobes;
  logic       warmDone, rcRunning, xtalRunning;

  clk_sw_ctrl #(.DATA_W(DATA_W)) i_ctrl (
    .busClk(busClk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .rcStop(rcStop), .xtalStop(xtalStop), .waitSel(waitSel),
    .warmDone(warmDone), .rcRunning(rcRunning), .xtalRunning(xtalRunning),
    .strobes(strobes));

  clk_sw_datapath #(
    .LONG_WARM(LONG_WARM), .SHORT_WARM(SHORT_WARM), .SYNC_STAGES(SYNC_STAGES)
  ) i_datapath (
    .busClk(busClk), .rstN(rstN), .rcClk(rcClk), .xtalClk(xtalClk),
    .strobes(strobes), .warmDone(warmDone), .rcRunning(rcRunning),
    .xtalRunning(xtalRunning), .sysClk(sysClk));
endmodule

// File: tb/test_clk_src_switch.sv
`timescale 1ns/1ps
module test_clk_src_switch;
  localparam int RC_P   = 5;   // RC period in bus cycles (20 ns)
  localparam int XT_P   = 13;  // crystal period in bus cycles (52 ns)
  localparam int SLACK  = 100;

  logic busClk = 0, rstN = 0, wrEn = 0;
  logic [7:0] wrData = '0, rdData;
  logic rcClk = 0, xtalClk = 0, rcStop, xtalStop, waitSel, sysClk;
  int checks = 0, errors = 0, glitches = 0;
  realtime lastEdge = 0;

  always #2 busClk = ~busClk;
  initial forever begin #10; rcClk   = rcStop   ? 1'b0 : ~rcClk;   end
  initial forever begin #26; xtalClk = xtalStop ? 1'b0 : ~xtalClk; end

  clk_src_switch i_clk_src_switch (
    .busClk(busClk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .rcClk(rcClk), .xtalClk(xtalClk), .rcStop(rcStop), .xtalStop(xtalStop),
    .waitSel(waitSel), .sysClk(sysClk));

  // R9 glitch monitor: no sysClk half period shorter than 20 ns
  always @(sysClk) begin
    if (rstN && lastEdge > 0 && ($realtime - lastEdge) < 19.9) glitches++;
    lastEdge = $realtime;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] d);
    @(negedge busClk); wrEn = 1; wrData = d;
    @(negedge busClk); wrEn = 0;
  endtask

  // cycles from the write until bit 7 differs from its old value
  task automatic timedSwitch(input logic [7:0] d, output int n);
    logic old;
    old = rdData[7];
    regWrite(d);
    n = 1;
    while (rdData[7] == old && n < 8000) begin @(negedge busClk); n++; end
  endtask

  task automatic waitSrc(input logic s);
    for (int k = 0; k < 8000 && rdData[7] != s; k++) @(negedge busClk);
  endtask

  task automatic checkPeriod(input real expNs, input string req);
    realtime t1;
    @(posedge sysClk); t1 = $realtime;
    @(posedge sysClk);
    check(($realtime - t1) > expNs - 1 && ($realtime - t1) < expNs + 1, req,
          int'($realtime - t1), int'(expNs));
  endtask

  // {write data, expected readback after settling}
  localparam logic [15:0] VEC [8] = '{
    16'h04_04,   // R5 wait bit stored
    16'h40_00,   // R8 stop of running RC refused
    16'h20_20,   // R3 crystal stop while idle
    16'h00_00,   // R3 crystal enabled again
    16'h88_88,   // R2 switch to crystal, short warm-up
    16'hD8_C8,   // R3 R4 stop RC, test bit reads 0
    16'h23_00,   // R4 R8 back to RC, crystal stop refused, low bits read 0
    16'h00_00    // R1 quiet state
  };

  initial begin
    int n;
    repeat (5) @(negedge busClk);
    check(rdData == 8'h00, "R1 readback", rdData, 0);
    check({rcStop, xtalStop, waitSel} == 3'b000, "R1 outputs", {rcStop, xtalStop, waitSel}, 0);
    rstN = 1;
    repeat (40) @(negedge busClk);
    checkPeriod(40.0, "R1 R9 RC after reset");

    for (int i = 0; i < 8; i++) begin
      regWrite(VEC[i][15:8]);
      waitSrc(VEC[i][7]);
      repeat (3) @(negedge busClk);
      check(rdData == VEC[i][7:0], "R2 R3 R4 R5 R8 vector readback", rdData, VEC[i][7:0]);
      check({rcStop, xtalStop, waitSel} == {VEC[i][6], VEC[i][5], VEC[i][2]},
            "R3 R5 vector outputs", {rcStop, xtalStop, waitSel}, {VEC[i][6], VEC[i][5], VEC[i][2]});
    end

    // R2: source bit holds until the handover completes
    regWrite(8'h88);
    check(rdData[7] == 1'b0, "R2 early readback", rdData[7], 0);
    n = 2;
    while (rdData[7] == 1'b0 && n < 8000) begin @(negedge busClk); n++; end
    check(n >= 15 * XT_P && n <= 16 * XT_P + SLACK, "R6 short warm-up time", n, 16 * XT_P);
    checkPeriod(104.0, "R9 crystal divided");

    // R6 long warm-up back to RC
    timedSwitch(8'h00, n);
    check(n >= 255 * RC_P && n <= 256 * RC_P + SLACK, "R6 long warm-up time", n, 256 * RC_P);
    checkPeriod(40.0, "R9 RC divided");

    // R10: withdrawn request
    regWrite(8'h80);
    repeat (500) @(negedge busClk);
    regWrite(8'h00);
    repeat (5000) @(negedge busClk);
    check(rdData == 8'h00, "R10 withdrawn request", rdData, 0);
    checkPeriod(40.0, "R10 still RC");

    // R7: target stopped
    regWrite(8'h20);
    regWrite(8'hA8);
    repeat (4000) @(negedge busClk);
    check(rdData == 8'h28, "R7 stalled on stopped crystal", rdData, 8'h28);
    timedSwitch(8'h88, n);
    check(n >= 15 * XT_P && n <= 16 * XT_P + SLACK, "R7 completes once enabled", n, 16 * XT_P);
    check(rdData == 8'h88, "R7 readback after switch", rdData, 8'h88);
    regWrite(8'h08);
    waitSrc(1'b0);
    repeat (20) @(negedge busClk);
    check(rdData == 8'h08, "R2 back on RC", rdData, 8'h08);

    check(glitches == 0, "R9 no short sysClk pulse", glitches, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge busClk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule